// File: doc/BRIEF.md
# Nibble Scrambler Protection Pair

This block is a small protection device that answers a host on an 8-bit register bus. It holds two 4-bit state registers, here called the scrambler nibble (A) and the key nibble (B). Each register has its own chip select, and the host picks one of four offsets with a 2-bit offset field. The host uses it as a challenge-response check: it writes, reads back, and compares the reply with the value it expects.

A write to A never uses the write data. The offset picks one of four fixed networks. Each network forms every new bit as the XOR of chosen complemented bits of the old A. A write to B stores the upper data nibble XORed with a constant chosen by the offset. A read at offset 0 returns the selected register in the upper nibble. Reads at other offsets return filler: all ones for B, and an 8-bit pseudo-random byte for A.

Reads are registered. The reply appears on `rdata` one clock after the read strobe, and `rvalid` marks it for that one cycle. The block applies no back-pressure: every strobe is taken in the cycle it is presented, and the host must capture the reply in the cycle `rvalid` is high.

Top module: `scrm_pair`

## Requirements
- R1: After reset, A = 0, B = 0, `rvalid` = 0, `rdata` = 0x00, and the random generator holds 0x01.
- R2: With n = ~A (old value), a write to A loads {n2, n0^n1, n0, n3} at offset 0, {n2, n0, n3, n3^n1} at offset 1, {n0^n2, n1, n3, n2} at offset 2 and {n0, n3, n2^n3, n1} at offset 3. Each list is written from bit 3 down to bit 0. A holds its value when no A write occurs.
- R3: The write data has no effect on the next value of A.
- R4: A write to B loads wdata[7:4] XOR k, where k is 0x4, 0x1, 0x8 or 0x2 for offsets 0, 1, 2 or 3. wdata[3:0] is ignored. B holds its value when no B write occurs.
- R5: A read at offset 0 returns the selected register in bits 7:4, with bits 3:0 zero.
- R6: A read of B at offset 1, 2 or 3 returns 0xFF.
- R7: A read of A at offset 1, 2 or 3 returns the generator's current state, and then the generator advances one step. The step is s <= {s[6:0], s7^s5^s4^s3}. No other access changes the generator.
- R8: `rvalid` is high in exactly the cycles that follow a read strobe with either chip select active. `rdata` keeps its last value when no read occurs.
- R9: When both chip selects are active, a read returns A's view, and a write updates both A and B.
- R10: When a read and a write reach the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csel_a | input | 1 | Chip select for the scrambler nibble |
| csel_b | input | 1 | Chip select for the key nibble |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| ofs | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
The assertions check on every cycle:
- the read timing of `rvalid`, and that `rdata` holds when no read occurs;
- the zero low nibble on offset-0 reads and the all-ones filler for B;
- that A, B and the generator hold when nothing addresses them;
- that the generator never reaches the all-zero lock-up state.

Only the bench's scenarios can show the rest:
- the four scrambling networks, walked through many (state, offset) pairs;
- the per-offset key applied to every B nibble;
- the exact random sequence;
- the same-cycle and dual-select orderings.

// File: rtl/scrm_pkg.sv
package scrm_pkg;

  localparam int NIB_W = 4;
  localparam int OFS_W = 2;
  localparam int N_OFS = 1 << OFS_W;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [OFS_W-1:0] ofs_t;

  // source of the byte returned by a read
  typedef enum logic [1:0] {
    SRC_A_REG  = 2'd0,
    SRC_A_RND  = 2'd1,
    SRC_B_REG  = 2'd2,
    SRC_B_FILL = 2'd3
  } rsrc_e;

  // offset-selected XOR network over the complemented old nibble
  function automatic nib_t scramble(input ofs_t sel, input nib_t prev);
    nib_t n;
    nib_t r;
    n = ~prev;
    case (sel)
      2'd0:    r = {n[2],        n[0] ^ n[1], n[0],        n[3]};
      2'd1:    r = {n[2],        n[0],        n[3],        n[3] ^ n[1]};
      2'd2:    r = {n[0] ^ n[2], n[1],        n[3],        n[2]};
      default: r = {n[0],        n[3],        n[2] ^ n[3], n[1]};
    endcase
    return r;
  endfunction

  // per-offset constant mixed into key writes
  function automatic nib_t key_const(input ofs_t sel);
    nib_t r;
    case (sel)
      2'd0:    r = 4'h4;
      2'd1:    r = 4'h1;
      2'd2:    r = 4'h8;
      default: r = 4'h2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/scrm_a_next.sv
module scrm_a_next
  import scrm_pkg::*;
(
  input  ofs_t sel,
  input  nib_t cur,
  output nib_t nxt
);

  nib_t cand [N_OFS];

  // one network per offset, then a select
  for (genvar o = 0; o < N_OFS; o++) begin : g_net
    assign cand[o] = scramble(ofs_t'(o), cur);
  end

  assign nxt = cand[sel];

endmodule

// File: rtl/scrm_lfsr.sv
module scrm_lfsr #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     SEED = 8'h01,
  parameter logic [W-1:0]     TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] s_q;
  logic         fb;

  assign fb    = ^(s_q & TAPS);
  assign state = s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q <= SEED;
    end else if (step) begin
      s_q <= {s_q[W-2:0], fb};
    end
  end

endmodule

// File: rtl/scrm_rd_port.sv
module scrm_rd_port
  import scrm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  rsrc_e             src,
  input  nib_t              a_val,
  input  nib_t              b_val,
  input  logic [DATA_W-1:0] rnd,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int PAD_W = DATA_W - NIB_W;

  logic [DATA_W-1:0] sel_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    case (src)
      SRC_A_REG:  sel_d = {a_val, {PAD_W{1'b0}}};
      SRC_A_RND:  sel_d = rnd;
      SRC_B_REG:  sel_d = {b_val, {PAD_W{1'b0}}};
      default:    sel_d = {DATA_W{1'b1}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= fire;
      if (fire) rdata_q <= sel_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/scrm_pair.sv
module scrm_pair
  import scrm_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] RND_SEED = 8'h01,
  parameter logic [DATA_W-1:0] RND_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csel_a,
  input  logic              csel_b,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int LOW_W = DATA_W - NIB_W;

  nib_t              a_q, b_q, a_d;
  logic              wr_a, wr_b, rd_a, rd_b, rd_fire, ofs_zero, rnd_step;
  logic [DATA_W-1:0] rnd_q;
  rsrc_e             src;
  logic              unused_wdata_low;

  assign unused_wdata_low = ^wdata[LOW_W-1:0];

  assign wr_a     = wr_en & csel_a;
  assign wr_b     = wr_en & csel_b;
  assign rd_a     = rd_en & csel_a;
  assign rd_b     = rd_en & csel_b & ~csel_a;
  assign rd_fire  = rd_a | rd_b;
  assign ofs_zero = (ofs == '0);
  assign rnd_step = rd_a & ~ofs_zero;

  always_comb begin
    if (rd_a) src = ofs_zero ? SRC_A_REG : SRC_A_RND;
    else      src = ofs_zero ? SRC_B_REG : SRC_B_FILL;
  end

  scrm_a_next u_next (
    .sel (ofs),
    .cur (a_q),
    .nxt (a_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a) a_q <= a_d;
      if (wr_b) b_q <= wdata[DATA_W-1 -: NIB_W] ^ key_const(ofs);
    end
  end

  scrm_lfsr #(
    .W    (DATA_W),
    .SEED (RND_SEED),
    .TAPS (RND_TAPS)
  ) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rnd_step),
    .state (rnd_q)
  );

  scrm_rd_port #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (rd_fire),
    .src    (src),
    .a_val  (a_q),
    .b_val  (b_q),
    .rnd    (rnd_q),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

endmodule

// File: rtl/scrm_pair_chk.sv
module scrm_pair_chk
  import scrm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csel_a,
  input logic              csel_b,
  input logic              wr_en,
  input logic              rd_en,
  input logic [OFS_W-1:0]  ofs,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic [NIB_W-1:0]  a_q,
  input logic [NIB_W-1:0]  b_q,
  input logic [DATA_W-1:0] rnd_q
);

  p_rvalid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (csel_a || csel_b)) |=> rvalid);

  p_rvalid_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (csel_a || csel_b)) |=> !rvalid);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (csel_a || csel_b)) |=> $stable(rdata));

  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (csel_a || csel_b) && ofs == '0) |=> (rdata[NIB_W-1:0] == '0));

  p_b_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && csel_b && !csel_a && ofs != '0) |=> (rdata == {DATA_W{1'b1}}));

  p_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && csel_a) |=> $stable(a_q));

  p_b_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && csel_b) |=> $stable(b_q));

  p_rnd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && csel_a && ofs != '0) |=> $stable(rnd_q));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_rnd_live_r7: assert (rnd_q != '0);
    end
  end

endmodule

bind scrm_pair scrm_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .csel_a (csel_a),
  .csel_b (csel_b),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .ofs    (ofs),
  .rdata  (rdata),
  .rvalid (rvalid),
  .a_q    (a_q),
  .b_q    (b_q),
  .rnd_q  (rnd_q)
);

// File: tb/tb_scrm_pair.sv
`timescale 1ns/1ps
module tb_scrm_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csel_a = 1'b0, csel_b = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] ofs = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] ma, mb;
  logic [7:0] mr;

  always #2.5 clk = ~clk;

  scrm_pair dut (
    .clk(clk), .rst_n(rst_n), .csel_a(csel_a), .csel_b(csel_b),
    .wr_en(wr_en), .rd_en(rd_en), .ofs(ofs), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [3:0] exp_a(input logic [1:0] o, input logic [3:0] a);
    int n, b0, b1, b2, b3;
    n = (~a) & 15;
    case (o)
      2'd0: begin b0 = n >> 3; b1 = n; b2 = n ^ (n >> 1); b3 = n >> 2; end
      2'd1: begin b0 = (n >> 3) ^ (n >> 1); b1 = n >> 3; b2 = n; b3 = n >> 2; end
      2'd2: begin b0 = n >> 2; b1 = n >> 3; b2 = n >> 1; b3 = n ^ (n >> 2); end
      default: begin b0 = n >> 1; b1 = (n >> 2) ^ (n >> 3); b2 = n >> 3; b3 = n; end
    endcase
    return 4'((b0 & 1) + 2 * (b1 & 1) + 4 * (b2 & 1) + 8 * (b3 & 1));
  endfunction

  function automatic logic [3:0] exp_key(input logic [1:0] o);
    return (o == 2'd0) ? 4'h4 : (o == 2'd1) ? 4'h1 : (o == 2'd2) ? 4'h8 : 4'h2;
  endfunction

  function automatic logic [7:0] exp_step(input logic [7:0] s);
    int fb;
    fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
    return 8'(((int'(s) * 2) + fb) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at a falling edge, observe at the next falling edge
  task automatic op(input logic ca, input logic cb, input logic rd, input logic wr,
                    input logic [1:0] o, input logic [7:0] d,
                    output logic [7:0] v, output logic vl);
    @(negedge clk);
    csel_a = ca; csel_b = cb; rd_en = rd; wr_en = wr; ofs = o; wdata = d;
    @(negedge clk);
    v = rdata; vl = rvalid;
    csel_a = 0; csel_b = 0; rd_en = 0; wr_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       vl;
    ma = 0; mb = 0; mr = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rvalid", {7'd0, rvalid}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
    check("R1 A after reset", v, 8'h00);
    op(0, 1, 1, 0, 2'd0, 8'h00, v, vl);
    check("R1 B after reset", v, 8'h00);
    check("R8 rvalid after read", {7'd0, vl}, 8'h01);

    // R2 R3: walk the A networks, write data varies and must not matter
    for (int i = 0; i < 256; i++) begin
      logic [1:0] o;
      o = 2'((i + (i >> 2) + (i >> 4)) & 3);
      op(1, 0, 0, 1, o, 8'((i * 37) ^ 8'h5A), v, vl);
      ma = exp_a(o, ma);
      check("R8 no rvalid on write", {7'd0, vl}, 8'h00);
      op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
      check("R2 R3 R5 A read", v, {ma, 4'h0});
    end

    // R4: every nibble at every offset, low data bits varied
    for (int n = 0; n < 16; n++) begin
      for (int o = 0; o < 4; o++) begin
        op(0, 1, 0, 1, 2'(o), 8'((n << 4) | ((n * 7 + o) & 15)), v, vl);
        mb = 4'(n) ^ exp_key(2'(o));
        op(0, 1, 1, 0, 2'd0, 8'h00, v, vl);
        check("R4 R5 B read", v, {mb, 4'h0});
      end
    end
    op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
    check("R4 A untouched by B writes", v, {ma, 4'h0});

    // R6 R7: random reads of A, filler reads of B, offset-0 reads do not advance
    for (int j = 0; j < 40; j++) begin
      op(1, 0, 1, 0, 2'(1 + (j % 3)), 8'h00, v, vl);
      check("R7 random byte", v, mr);
      mr = exp_step(mr);
      if (j % 5 == 0) begin
        op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
        check("R5 A read between random", v, {ma, 4'h0});
        op(0, 1, 1, 0, 2'(1 + (j % 3)), 8'h00, v, vl);
        check("R6 B filler", v, 8'hFF);
        op(1, 0, 0, 1, 2'(j % 4), 8'h00, v, vl);
        ma = exp_a(2'(j % 4), ma);
      end
    end

    // R9: both selects
    op(1, 1, 1, 0, 2'd0, 8'h00, v, vl);
    check("R9 dual read gives A", v, {ma, 4'h0});
    op(1, 1, 1, 0, 2'd2, 8'h00, v, vl);
    check("R9 dual read gives random", v, mr);
    mr = exp_step(mr);
    op(1, 1, 0, 1, 2'd3, 8'hC6, v, vl);
    ma = exp_a(2'd3, ma);
    mb = 4'hC ^ exp_key(2'd3);
    op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
    check("R9 dual write A", v, {ma, 4'h0});
    op(0, 1, 1, 0, 2'd0, 8'h00, v, vl);
    check("R9 dual write B", v, {mb, 4'h0});

    // R10: read and write in the same cycle
    op(1, 0, 1, 1, 2'd0, 8'h00, v, vl);
    check("R10 A read sees old", v, {ma, 4'h0});
    ma = exp_a(2'd0, ma);
    op(0, 1, 1, 1, 2'd0, 8'h90, v, vl);
    check("R10 B read sees old", v, {mb, 4'h0});
    mb = 4'h9 ^ exp_key(2'd0);
    op(1, 0, 1, 0, 2'd0, 8'h00, v, vl);
    check("R10 A new", v, {ma, 4'h0});
    op(0, 1, 1, 0, 2'd0, 8'h00, v, vl);
    check("R10 B new", v, {mb, 4'h0});

    // R8: read strobe without chip select, then idle
    op(0, 0, 1, 0, 2'd1, 8'h00, v, vl);
    check("R8 no select no rvalid", {7'd0, vl}, 8'h00);
    check("R8 rdata held", v, {mb, 4'h0});
    @(negedge clk);
    check("R8 idle rvalid low", {7'd0, rvalid}, 8'h00);
    op(1, 0, 1, 0, 2'd1, 8'h00, v, vl);
    check("R7 no advance from others", v, mr);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule